// File: doc/BRIEF.md
# Hashed Interleaving Address Mapper

This block turns an incoming 48-bit address into a memory unit number and a word offset within that unit. It first scrambles the address with a 48x48 bit matrix over GF(2). Logical bit i is the XOR of the address bits picked out by matrix row i. A regular stride therefore lands on units with no pattern that repeats. The three lowest logical bits select a byte inside the 64-bit word. They pass straight through to the output.

The remaining word address is spread over the memory units. There are 2^k times m units, where m is an odd divisor of 315. The low k bits of the word address feed the power-of-two part of the unit number. The rest is divided by m in a fixed-latency pipelined divider. The remainder gives the odd part of the unit number and the quotient gives the offset. The divider accepts one address per clock.

Configuration writes land in a staging copy of the matrix and of the geometry (k, m). The staged values take effect only after every address already in flight has left the pipeline. New input is held off until then. Software must supply an invertible matrix and a legal geometry.

Top module: `hashed_addr_mapper`

## Requirements
- R1: Logical address bit i equals the XOR over j of (row i bit j AND input address bit j), using the matrix in effect when the address is accepted.
- R2: Logical bits 2..0 appear unchanged on `out_byte`.
- R3: With w = logical[47:3] and x = w >> k: `out_unit` = (x mod m)·2^k + (w mod 2^k) and `out_offset` = x / m. Only m values that divide 315 (m = 1, 3, 5, 7, 9, 15, 21, 35, 45, 63, 105, 315) and k values of at most 8 may be written.
- R4: With `out_ready` held high, an address accepted at clock edge N is presented on the output after edge N+5 and not before. Back-to-back addresses are accepted on consecutive edges.
- R5: While `out_valid` is high and `out_ready` is low, the output fields stay stable. Results leave in acceptance order, with none lost and none repeated.
- R6: A row or geometry write drops `in_ready` until the pipeline is empty and the staged values are installed. Addresses already in flight still use the previous matrix and geometry.
- R7: After reset the matrix is the identity, k = 0 and m = 1, `out_valid` is low and `in_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_row_we | input | 1 | Write one staged matrix row |
| cfg_row_idx | input | 6 | Row (logical output bit) being written |
| cfg_row_bits | input | 48 | Row contents; bit j selects address bit j |
| cfg_geo_we | input | 1 | Write the staged geometry |
| cfg_geo_k | input | 4 | Power-of-two exponent k |
| cfg_geo_m | input | 9 | Odd factor m |
| in_valid | input | 1 | Address present |
| in_ready | output | 1 | Address accepted this cycle when valid |
| in_addr | input | 48 | Address to map |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_unit | output | 17 | Memory unit number |
| out_offset | output | 45 | Word offset within the unit |
| out_byte | output | 3 | Byte select within the word |

## Verification
The identity matrix with k = 0, m = 1 shows the scramble and split as plain wiring. A sequence of addresses with a fixed stride under m = 3, k = 2 tests whether the remainder and quotient advance correctly across unit boundaries. All-ones addresses under m = 315 exercise the widest remainder and the longest borrow chains in the divider. A pseudo-random matrix under m = 45, k = 3, with random backpressure, separates row-selection or bit-order errors from handshake faults. A matrix write issued while addresses are stalled inside the pipeline shows whether the new configuration leaks into results that are already in flight.

// File: rtl/ham_pkg.sv
`timescale 1ns/1ps
package ham_pkg;
   localparam int ODD_BASE = 315;

   function automatic logic odd_factor_ok(input int unsigned m);
      return (m != 0) && ((ODD_BASE % m) == 0);
   endfunction
endpackage

// File: rtl/ham_matrix.sv
`timescale 1ns/1ps
module ham_matrix #(
   parameter int AW = 48
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [$clog2(AW)-1:0]  wr_idx,
   input  logic [AW-1:0]          wr_row,
   input  logic                   apply,
   input  logic [AW-1:0]          addr_i,
   output logic [AW-1:0]          logical_o
);
   logic [AW-1:0][AW-1:0] stg_q, act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < AW; i++) begin
            stg_q[i] <= AW'(1) << i;
            act_q[i] <= AW'(1) << i;
         end
      end else begin
         if (wr_en) stg_q[wr_idx] <= wr_row;
         if (apply) act_q <= stg_q;
      end
   end

   always_comb begin
      for (int i = 0; i < AW; i++) logical_o[i] = ^(act_q[i] & addr_i);
   end

   // R6: the active matrix never changes except on an install
   a_r6_matrix_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(act_q));
endmodule

// File: rtl/ham_div_step.sv
`timescale 1ns/1ps
module ham_div_step #(
   parameter int PW     = 45,
   parameter int DB     = 9,
   parameter int J      = 0,
   parameter int M_W    = 9,
   parameter int SIDE_W = 11
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              vld_i,
   input  logic [PW-1:0]     x_i,
   input  logic [PW-1:0]     q_i,
   input  logic [M_W-1:0]    r_i,
   input  logic [SIDE_W-1:0] side_i,
   input  logic [M_W-1:0]    m_i,
   output logic              vld_o,
   output logic [PW-1:0]     x_o,
   output logic [PW-1:0]     q_o,
   output logic [M_W-1:0]    r_o,
   output logic [SIDE_W-1:0] side_o
);
   localparam int HI = PW - 1 - J * DB;

   logic [PW-1:0]  q_n;
   logic [M_W-1:0] r_n;

   always_comb begin
      logic [M_W:0] t;
      q_n = q_i;
      r_n = r_i;
      for (int b = 0; b < DB; b++) begin
         if (HI - b >= 0) begin
            t = {r_n, x_i[HI-b]};
            if (t >= {1'b0, m_i}) begin
               t = t - {1'b0, m_i};
               q_n[HI-b] = 1'b1;
            end
            r_n = t[M_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         x_o    <= '0;
         q_o    <= '0;
         r_o    <= '0;
         side_o <= '0;
      end else if (en) begin
         vld_o  <= vld_i;
         x_o    <= x_i;
         q_o    <= q_n;
         r_o    <= r_n;
         side_o <= side_i;
      end
   end

   // R3: a partial remainder always stays below the divisor
   a_r3_rem_below_m: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (r_o < m_i));
endmodule

// File: rtl/hashed_addr_mapper.sv
`timescale 1ns/1ps
module hashed_addr_mapper
   import ham_pkg::*;
#(
   parameter int ADDR_W     = 48,
   parameter int BYTE_W     = 3,
   parameter int K_MAX      = 8,
   parameter int M_W        = 9,
   parameter int DIV_STAGES = 5
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_row_we,
   input  logic [$clog2(ADDR_W)-1:0]    cfg_row_idx,
   input  logic [ADDR_W-1:0]            cfg_row_bits,
   input  logic                         cfg_geo_we,
   input  logic [$clog2(K_MAX+1)-1:0]   cfg_geo_k,
   input  logic [M_W-1:0]               cfg_geo_m,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [ADDR_W-1:0]            in_addr,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [M_W+K_MAX-1:0]         out_unit,
   output logic [ADDR_W-BYTE_W-1:0]     out_offset,
   output logic [BYTE_W-1:0]            out_byte
);
   localparam int WORD_W   = ADDR_W - BYTE_W;
   localparam int DIV_BITS = (WORD_W + DIV_STAGES - 1) / DIV_STAGES;
   localparam int PAD_W    = DIV_BITS * DIV_STAGES;
   localparam int K_W      = $clog2(K_MAX + 1);
   localparam int UNIT_W   = M_W + K_MAX;
   localparam int SIDE_W   = K_MAX + BYTE_W;

   if (DIV_STAGES < 1 || DIV_STAGES > 7) begin : g_bad_stages
      $error("DIV_STAGES must give a latency of 8 cycles or less");
   end
   if (K_MAX > WORD_W || BYTE_W < 1) begin : g_bad_widths
      $error("K_MAX or BYTE_W out of range");
   end
   if ((1 << M_W) <= ODD_BASE) begin : g_bad_mw
      $error("M_W too narrow for the odd factor");
   end

   // configuration staging and install
   logic           pend_q, empty, apply, en;
   logic [K_W-1:0] k_stg, k_act;
   logic [M_W-1:0] m_stg, m_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         k_stg  <= '0;
         k_act  <= '0;
         m_stg  <= M_W'(1);
         m_act  <= M_W'(1);
      end else begin
         pend_q <= cfg_row_we | cfg_geo_we | (pend_q & ~empty);
         if (cfg_geo_we) begin
            k_stg <= cfg_geo_k;
            m_stg <= cfg_geo_m;
         end
         if (apply) begin
            k_act <= k_stg;
            m_act <= m_stg;
         end
      end
   end

   assign en       = ~out_valid | out_ready;
   assign in_ready = en & ~pend_q;
   assign apply    = pend_q & empty;

   // stage 0: scramble
   logic [ADDR_W-1:0] logical, lg_q;
   logic              v0_q;

   ham_matrix #(.AW(ADDR_W)) u_matrix (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_row_we), .wr_idx(cfg_row_idx), .wr_row(cfg_row_bits),
      .apply(apply), .addr_i(in_addr), .logical_o(logical)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v0_q <= 1'b0;
         lg_q <= '0;
      end else if (en) begin
         v0_q <= in_valid & in_ready;
         lg_q <= logical;
      end
   end

   // split word address into shifted dividend and low unit bits
   logic [WORD_W-1:0] word;
   logic [K_MAX-1:0]  low;

   assign word = lg_q[ADDR_W-1:BYTE_W];
   always_comb begin
      for (int i = 0; i < K_MAX; i++) low[i] = word[i] & (K_W'(i) < k_act);
   end

   // divider chain
   logic              vld_a  [DIV_STAGES+1];
   logic [PAD_W-1:0]  x_a    [DIV_STAGES+1];
   logic [PAD_W-1:0]  q_a    [DIV_STAGES+1];
   logic [M_W-1:0]    r_a    [DIV_STAGES+1];
   logic [SIDE_W-1:0] side_a [DIV_STAGES+1];

   assign vld_a[0]  = v0_q;
   assign x_a[0]    = PAD_W'(word >> k_act);
   assign q_a[0]    = '0;
   assign r_a[0]    = '0;
   assign side_a[0] = {low, lg_q[BYTE_W-1:0]};

   for (genvar j = 0; j < DIV_STAGES; j++) begin : g_div
      ham_div_step #(
         .PW(PAD_W), .DB(DIV_BITS), .J(j), .M_W(M_W), .SIDE_W(SIDE_W)
      ) u_step (
         .clk(clk), .rst_n(rst_n), .en(en),
         .vld_i(vld_a[j]), .x_i(x_a[j]), .q_i(q_a[j]), .r_i(r_a[j]),
         .side_i(side_a[j]), .m_i(m_act),
         .vld_o(vld_a[j+1]), .x_o(x_a[j+1]), .q_o(q_a[j+1]), .r_o(r_a[j+1]),
         .side_o(side_a[j+1])
      );
   end

   always_comb begin
      empty = ~v0_q;
      for (int j = 1; j <= DIV_STAGES; j++) empty = empty & ~vld_a[j];
   end

   // output assembly
   assign out_valid  = vld_a[DIV_STAGES];
   assign out_unit   = (UNIT_W'(r_a[DIV_STAGES]) << k_act)
                     | UNIT_W'(side_a[DIV_STAGES][SIDE_W-1:BYTE_W]);
   assign out_offset = q_a[DIV_STAGES][WORD_W-1:0];
   assign out_byte   = side_a[DIV_STAGES][BYTE_W-1:0];

   // R3: only legal geometries are written
   a_r3_geometry_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_geo_we |-> (odd_factor_ok(32'(cfg_geo_m)) && (32'(cfg_geo_k) <= K_MAX)));
   // R5: a stalled result holds
   a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_unit)
                                     && $stable(out_offset) && $stable(out_byte)));
   // R8: a blocked output blocks the input
   a_r8_full_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
   // R6: staged configuration holds off new addresses
   a_r6_pending_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_row_we || cfg_geo_we) |-> !in_ready);
   // R6: geometry cannot change under addresses in flight
   a_r6_geometry_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !empty |=> ($stable(k_act) && $stable(m_act)));
   // R4: an accepted address enters stage 0
   a_r4_accept_enters: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> v0_q);
endmodule

// File: tb/hashed_addr_mapper_tb.sv
`timescale 1ns/1ps
module hashed_addr_mapper_tb;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_row_we, cfg_geo_we;
   logic [5:0]  cfg_row_idx;
   logic [47:0] cfg_row_bits;
   logic [3:0]  cfg_geo_k;
   logic [8:0]  cfg_geo_m;
   logic        in_valid, in_ready, out_valid, out_ready;
   logic [47:0] in_addr;
   logic [16:0] out_unit;
   logic [44:0] out_offset;
   logic [2:0]  out_byte;

   always #2 clk = ~clk;

   hashed_addr_mapper u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_row_we(cfg_row_we), .cfg_row_idx(cfg_row_idx), .cfg_row_bits(cfg_row_bits),
      .cfg_geo_we(cfg_geo_we), .cfg_geo_k(cfg_geo_k), .cfg_geo_m(cfg_geo_m),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_unit(out_unit), .out_offset(out_offset), .out_byte(out_byte)
   );

   int checks = 0, fails = 0, cyc = 0, acc_cyc = 0, bp_mode = 0;
   logic [47:0] bmat [48];
   int          bk = 0, bm = 1;
   logic [64:0] exp_q [$];
   string       tag_q [$];
   logic [31:0] lfsr = 32'h1234_5678;

   always @(posedge clk) cyc++;

   function automatic logic [31:0] nxt(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   function automatic logic [64:0] predict(input logic [47:0] a);
      logic [47:0] lg;
      logic [44:0] w, x, lo;
      for (int i = 0; i < 48; i++) lg[i] = ^(bmat[i] & a);
      w  = lg[47:3];
      x  = w >> bk;
      lo = w & ((45'd1 << bk) - 45'd1);
      return {17'((x % 45'(bm)) << bk) | 17'(lo), x / 45'(bm), lg[2:0]};
   endfunction

   task automatic check(input logic ok, input string req, input logic [64:0] act, input logic [64:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   // backpressure driver
   always @(negedge clk) begin
      lfsr = nxt(lfsr);
      case (bp_mode)
         0: out_ready = 1'b1;
         1: out_ready = lfsr[3] | lfsr[7];
         default: out_ready = 1'b0;
      endcase
   end

   // scoreboard monitor
   always @(negedge clk) begin
      #0.6;
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected result", {out_unit, out_offset, out_byte}, '0);
         end else begin
            logic [64:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({out_unit, out_offset, out_byte} == e, t, {out_unit, out_offset, out_byte}, e);
         end
      end
   end

   task automatic send(input logic [47:0] a, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_addr  = a;
      #0.3;
      while (!in_ready) begin
         @(negedge clk);
         #0.3;
      end
      exp_q.push_back(predict(a));
      tag_q.push_back(tag);
      @(posedge clk);
      acc_cyc = cyc;
      #0.5;
      in_valid = 1'b0;
   endtask

   task automatic write_row(input int idx, input logic [47:0] bits);
      @(negedge clk);
      cfg_row_we = 1'b1; cfg_row_idx = 6'(idx); cfg_row_bits = bits;
      bmat[idx] = bits;
      @(posedge clk);
      #0.5;
      cfg_row_we = 1'b0;
   endtask

   task automatic write_geo(input int k, input int m);
      @(negedge clk);
      cfg_geo_we = 1'b1; cfg_geo_k = 4'(k); cfg_geo_m = 9'(m);
      bk = k; bm = m;
      @(posedge clk);
      #0.5;
      cfg_geo_we = 1'b0;
   endtask

   task automatic drain;
      int n = 0;
      while (exp_q.size() != 0 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check(exp_q.size() == 0, "R5 drain", 65'(exp_q.size()), '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 48; i++) bmat[i] = 48'd1 << i;
      rst_n = 1'b0; in_valid = 1'b0; in_addr = '0;
      cfg_row_we = 1'b0; cfg_geo_we = 1'b0; cfg_row_idx = '0; cfg_row_bits = '0;
      cfg_geo_k = '0; cfg_geo_m = 9'd1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #0.3;
      // R7: reset state
      check(out_valid == 1'b0, "R7 out_valid", 65'(out_valid), 65'd0);
      check(in_ready == 1'b1, "R7 in_ready", 65'(in_ready), 65'd1);
      // R7 / R2: identity map, one unit
      send(48'h0000_0000_0007, "R7");
      send(48'hDEAD_BEEF_1235, "R2");
      send(48'hFFFF_FFFF_FFFF, "R7");
      drain();

      // R4: latency
      send(48'h0000_0000_1000, "R4");
      repeat (4) @(posedge clk);
      @(negedge clk); #0.3;
      check(out_valid == 1'b0, "R4 early", 65'(out_valid), 65'd0);
      @(posedge clk);
      @(negedge clk); #0.3;
      check(out_valid == 1'b1, "R4 on time", 65'(out_valid), 65'd1);
      drain();

      // R4: one per cycle
      begin
         int first;
         send(48'h100, "R4");
         first = acc_cyc;
         for (int i = 1; i < 8; i++) send(48'h100 + 48'(i * 8), "R4");
         check(acc_cyc - first == 7, "R4 throughput", 65'(acc_cyc - first), 65'd7);
      end
      drain();

      // R3: stride walk with m=3, k=2
      write_geo(2, 3);
      for (int i = 0; i < 16; i++) send(48'(i * 8), "R3");
      drain();
      // R3: largest odd factor, all-ones and edge addresses
      write_geo(0, 315);
      send(48'hFFFF_FFFF_FFFF, "R3");
      send(48'h0000_0000_09D8, "R3");
      send(48'h8000_0000_0000, "R3");
      send(48'h7FFF_FFFF_FFF8, "R3");
      drain();
      write_geo(8, 1);
      send(48'hABCD_EF01_2345, "R3");
      send(48'h0000_0000_07F8, "R3");
      drain();

      // R1: pseudo-random matrix, m=45, k=3, random backpressure (R5)
      for (int i = 0; i < 48; i++) begin
         lfsr = nxt(nxt(lfsr));
         write_row(i, {lfsr[15:0], lfsr} ^ (48'd1 << i));
      end
      write_geo(3, 45);
      bp_mode = 1;
      for (int i = 0; i < 24; i++) begin
         lfsr = nxt(lfsr);
         send({lfsr[23:0], nxt(lfsr)[23:0]}, (i % 2) ? "R1" : "R5");
      end
      drain();
      bp_mode = 0;

      // R8 / R5 / R6: stall the pipe full, then stage a new row
      bp_mode = 2;
      send(48'h1111_2222_3338, "R6");
      send(48'h4444_5555_6660, "R6");
      send(48'h7777_8888_9999, "R6");
      repeat (8) @(negedge clk);
      #0.3;
      check(in_ready == 1'b0, "R8 in_ready while blocked", 65'(in_ready), 65'd0);
      begin
         logic [64:0] held;
         held = {out_unit, out_offset, out_byte};
         repeat (3) @(negedge clk);
         #0.3;
         check({out_unit, out_offset, out_byte} == held, "R5 held output",
               {out_unit, out_offset, out_byte}, held);
      end
      write_row(5, 48'hFFFF_FFFF_FFFF);
      @(negedge clk); #0.3;
      check(in_ready == 1'b0, "R6 in_ready while pending", 65'(in_ready), 65'd0);
      bp_mode = 0;
      send(48'h1111_2222_3338, "R6");
      send(48'h0000_0000_0020, "R6");
      drain();
      @(negedge clk); #0.3;
      check(in_ready == 1'b1, "R6 ready after install", 65'(in_ready), 65'd1);

      finish_run();
   end
endmodule